// File: doc/BRIEF.md
# Serial Packet Transmitter with Replay

The block shifts a fixed-length packet out one bit per clock, paired with a strobe that marks each valid bit. A start request can take either of two forms. A fresh start latches the packet presented on the input bus. A replay start sends again whatever packet was last latched. A small bit counter tracks which packet bit is on the line. The counter rests at zero when idle and reads one on the cycle after the first bit.

Start requests are refused in three cases: while reset is held, during the two-cycle synchronous release of reset, and while a packet is still going out. A start refused because the line is busy also sets a protocol-error flag. That flag stays set until the next reset. On each accepted start, the packet type code is checked against a parameter mask of legal encodings, and an illegal code is reported in the same cycle.

Top module: `sptx_top`

## Requirements
- R1: While rst_n is low, tx_valid_o, tx_data_o, busy_o, type_illegal_o and proto_err_o are all 0.
- R2: A start is accepted when start_i is high, reset is fully released and busy_o is low. In that same cycle tx_valid_o is 1 and tx_data_o carries bit 0 of the packet: pkt_i[0] when new_pkt_i is 1, or bit 0 of the stored packet when new_pkt_i is 0.
- R3: On the PKT_LEN-1 clocks after an accepted start, tx_valid_o is 1 and tx_data_o carries packet bits 1, 2, … PKT_LEN-1 in ascending order. Whenever tx_valid_o is 0, tx_data_o is 0.
- R4: busy_o is 1 exactly on the cycles that follow an accepted start, up to and including the cycle that sends the last bit. A new start is therefore accepted at the earliest on the cycle right after the last bit.
- R5: rst_n is asynchronous and active low. Its release takes effect after two rising clock edges. A start issued during reset or during those two cycles is ignored and produces no valid bit.
- R6: A start issued while busy_o is 1 is ignored, and the packet in flight continues unchanged.
- R7: A replay start (new_pkt_i = 0) resends the most recently latched packet. If no fresh packet has been latched since reset, it sends all zeros.
- R8: The stored packet changes only on an accepted start with new_pkt_i = 1. pkt_i is ignored at all other times.
- R9: type_illegal_o is 1 exactly in a start-accept cycle whose type_i value k has bit k of LEGAL_MASK clear. It is 0 in every other cycle.
- R10: proto_err_o becomes 1 on the clock after a start is issued while busy_o is 1. It then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request |
| new_pkt_i | input | 1 | 1 = latch and send pkt_i, 0 = replay stored packet |
| pkt_i | input | PKT_LEN | Fresh packet contents, bit 0 sent first |
| type_i | input | TYPE_W | Packet type code |
| tx_valid_o | output | 1 | Serial bit valid |
| tx_data_o | output | 1 | Serial bit |
| busy_o | output | 1 | Transmission in progress after the first bit |
| type_illegal_o | output | 1 | Accepted start carries an illegal type |
| proto_err_o | output | 1 | Sticky: start seen while busy |

## Verification
The bench builds the block with PKT_LEN = 6, which is not a power of two. With that length the counter must wrap at 5 rather than at its natural rollover, and the padded bit-select never reaches the unused entries. TYPE_W = 2 with LEGAL_MASK = 4'b1011 makes code 2 the single illegal encoding, so random type codes hit the illegal-type path about a quarter of the time. The short packet gives frequent back-to-back starts, busy collisions and mid-packet resets within a modest run.

// File: rtl/sptx_pkg.sv
package sptx_pkg;

  function automatic int ptr_width(input int len);
    return (len <= 2) ? 1 : $clog2(len);
  endfunction

  typedef struct packed {
    logic accept;
    logic is_new;
    logic collide;
  } start_dec_t;

endpackage

// File: rtl/sptx_rst_sync.sv
module sptx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = 1'b1;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_s = chain_q[STAGES-1];
endmodule

// File: rtl/sptx_guard.sv
module sptx_guard
  import sptx_pkg::*;
#(
  parameter int TYPE_W = 2,
  parameter logic [(1<<TYPE_W)-1:0] LEGAL_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n_s,
  input  logic              start_i,
  input  logic              new_pkt_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic              busy_i,
  output start_dec_t        dec_o,
  output logic              type_illegal_o,
  output logic              proto_err_o
);
  logic err_q, err_d, err_en;
  logic type_ok;

  always_comb begin
    dec_o.accept  = rst_n_s & start_i & ~busy_i;
    dec_o.is_new  = new_pkt_i;
    dec_o.collide = rst_n_s & start_i & busy_i;
  end

  assign type_ok        = LEGAL_MASK[type_i];
  assign type_illegal_o = dec_o.accept & ~type_ok;

  assign err_en = dec_o.collide & ~err_q;
  assign err_d  = 1'b1;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  assign proto_err_o = err_q;

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    proto_err_o |=> proto_err_o);
  p_collide_flags_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (start_i && busy_i) |=> proto_err_o);
endmodule

// File: rtl/sptx_ptr.sv
module sptx_ptr
  import sptx_pkg::*;
#(
  parameter int PKT_LEN = 8,
  localparam int PTR_W = ptr_width(PKT_LEN)
) (
  input  logic             clk,
  input  logic             rst_n_s,
  input  logic             accept_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             busy_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(PKT_LEN-1);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    if (accept_i) begin
      ptr_d  = PTR_W'(1);
      ptr_en = 1'b1;
    end else if (ptr_q == LAST) begin
      ptr_d  = '0;
      ptr_en = 1'b1;
    end else if (ptr_q != '0) begin
      ptr_d  = ptr_q + PTR_W'(1);
      ptr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr_o  = ptr_q;
  assign busy_o = (ptr_q != '0);

  p_ptr_start_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    accept_i |=> (ptr_o == PTR_W'(1)));
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ptr_o != '0 && ptr_o != LAST) |=> (ptr_o == $past(ptr_o) + PTR_W'(1)));
  p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ptr_o == LAST) |=> (ptr_o == '0));
  p_ptr_range_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    ptr_o <= LAST);
endmodule

// File: rtl/sptx_store.sv
module sptx_store
  import sptx_pkg::*;
#(
  parameter int PKT_LEN = 8,
  localparam int PTR_W = ptr_width(PKT_LEN),
  localparam int PAD_LEN = 1 << PTR_W
) (
  input  logic               clk,
  input  logic               rst_n_s,
  input  logic               accept_i,
  input  logic               is_new_i,
  input  logic [PKT_LEN-1:0] pkt_i,
  input  logic [PTR_W-1:0]   ptr_i,
  output logic               tx_data_o
);
  logic [PKT_LEN-1:0] pkt_q;
  logic               load_en;
  logic [PAD_LEN-1:0] padded;
  logic               first_bit;
  logic               mid_bit;

  assign load_en = accept_i & is_new_i;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     pkt_q <= '0;
    else if (load_en) pkt_q <= pkt_i;
  end

  generate
    if (PAD_LEN > PKT_LEN) begin : g_pad
      assign padded = {{(PAD_LEN-PKT_LEN){1'b0}}, pkt_q};
    end else begin : g_nopad
      assign padded = pkt_q;
    end
  endgenerate

  assign first_bit = is_new_i ? pkt_i[0] : pkt_q[0];
  assign mid_bit   = (ptr_i != '0) ? padded[ptr_i] : 1'b0;
  assign tx_data_o = accept_i ? first_bit : mid_bit;

  p_store_hold_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(accept_i && is_new_i) |=> $stable(pkt_q));
  p_store_load_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (accept_i && is_new_i) |=> (pkt_q == $past(pkt_i)));
endmodule

// File: rtl/sptx_top.sv
module sptx_top
  import sptx_pkg::*;
#(
  parameter int PKT_LEN = 8,
  parameter int TYPE_W = 2,
  parameter logic [(1<<TYPE_W)-1:0] LEGAL_MASK = 4'b0111,
  localparam int PTR_W = ptr_width(PKT_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               new_pkt_i,
  input  logic [PKT_LEN-1:0] pkt_i,
  input  logic [TYPE_W-1:0]  type_i,
  output logic               tx_valid_o,
  output logic               tx_data_o,
  output logic               busy_o,
  output logic               type_illegal_o,
  output logic               proto_err_o
);
  logic             rst_n_s;
  start_dec_t       dec;
  logic [PTR_W-1:0] ptr;
  logic             busy;

  sptx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  sptx_guard #(.TYPE_W(TYPE_W), .LEGAL_MASK(LEGAL_MASK)) u_guard (
    .clk(clk), .rst_n_s(rst_n_s), .start_i(start_i), .new_pkt_i(new_pkt_i),
    .type_i(type_i), .busy_i(busy), .dec_o(dec),
    .type_illegal_o(type_illegal_o), .proto_err_o(proto_err_o)
  );

  sptx_ptr #(.PKT_LEN(PKT_LEN)) u_ptr (
    .clk(clk), .rst_n_s(rst_n_s), .accept_i(dec.accept),
    .ptr_o(ptr), .busy_o(busy)
  );

  sptx_store #(.PKT_LEN(PKT_LEN)) u_store (
    .clk(clk), .rst_n_s(rst_n_s), .accept_i(dec.accept), .is_new_i(dec.is_new),
    .pkt_i(pkt_i), .ptr_i(ptr), .tx_data_o(tx_data_o)
  );

  assign tx_valid_o = dec.accept | busy;
  assign busy_o     = busy;

  p_valid_reset_r5: assert property (@(posedge clk)
    !rst_n_s |-> !tx_valid_o);
  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy_o |-> !dec.accept);
  p_data_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    !tx_valid_o |-> !tx_data_o);
endmodule

// File: tb/sptx_top_tb.sv
module sptx_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LEN = 6;
  localparam int TW = 2;
  localparam logic [3:0] TB_LEGAL = 4'b1011;

  logic clk = 1'b0;
  logic rst_n;
  logic start, nw;
  logic [LEN-1:0] pkt;
  logic [TW-1:0] typ;
  logic tx_valid, tx_data, busy, illegal, perr;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  bit [LEN-1:0] m_store;
  int m_ptr, m_sc;
  bit m_err;
  string tag_ov = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  sptx_top #(.PKT_LEN(LEN), .TYPE_W(TW), .LEGAL_MASK(TB_LEGAL)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .new_pkt_i(nw), .pkt_i(pkt),
    .type_i(typ), .tx_valid_o(tx_valid), .tx_data_o(tx_data), .busy_o(busy),
    .type_illegal_o(illegal), .proto_err_o(perr)
  );

  task automatic check(input string tg, input string what, input logic got, input logic exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tg, what, got, exp, $time);
    end
  endtask

  function automatic int next_ptr(input int p, input bit acc);
    if (acc) return 1;
    if (p == LEN-1) return 0;
    if (p != 0) return p + 1;
    return 0;
  endfunction

  task automatic step(input bit r, input bit s, input bit n,
                      input logic [LEN-1:0] p, input logic [TW-1:0] t);
    bit live, acc, ev, ed;
    string tg;
    @(negedge clk);
    rst_n = r; start = s; nw = n; pkt = p; typ = t;
    if (!r) begin m_sc = 0; m_ptr = 0; m_err = 0; m_store = '0; end
    #1;
    live = r && (m_sc == 2);
    acc  = live && s && (m_ptr == 0);
    ev   = acc || (m_ptr != 0);
    ed   = acc ? (n ? p[0] : m_store[0]) : ((m_ptr != 0) ? m_store[m_ptr] : 1'b0);
    if (tag_ov != "")          tg = tag_ov;
    else if (!r)               tg = "R1";
    else if (!live)            tg = "R5";
    else if (acc)              tg = "R2";
    else if (s && m_ptr != 0)  tg = "R6";
    else                       tg = "R3";
    check(tg, "tx_valid", tx_valid, ev);
    check(tg, "tx_data", tx_data, ed);
    check(r ? "R4" : "R1", "busy", busy, m_ptr != 0);
    check(r ? "R9" : "R1", "type_illegal", illegal, acc && !TB_LEGAL[t]);
    check(r ? "R10" : "R1", "proto_err", perr, m_err);
    if (r) begin
      if (live && s && m_ptr != 0) m_err = 1;
      if (acc && n) m_store = p;
      m_ptr = live ? next_ptr(m_ptr, acc) : 0;
      if (m_sc < 2) m_sc++;
    end
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(1, 0, 0, '0, '0);
  endtask

  task automatic do_reset();
    step(0, 1, 1, '1, '0);
    step(0, 0, 0, '0, '0);
    step(1, 1, 1, 6'h2A, '0);
    step(1, 1, 1, 6'h15, '0);
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unused;
    unused = $urandom(32'h5EED_1234);
    rst_n = 0; start = 0; nw = 0; pkt = '0; typ = '0;
    do_reset();

    // R7: replay before any fresh packet sends zeros
    tag_ov = "R7";
    step(1, 1, 0, 6'h3F, 2'd0);
    idle(LEN);
    tag_ov = "";

    // R2/R3 fresh packet, then R4 back-to-back start on cycle after last bit
    step(1, 1, 1, 6'b101101, 2'd1);
    idle(LEN-1);
    step(1, 1, 1, 6'b010011, 2'd3);
    // R6/R10: collision mid-packet
    step(1, 1, 1, 6'b111111, 2'd0);
    idle(LEN);

    // R8: replay ignores pkt_i and resends last fresh packet
    tag_ov = "R8";
    step(1, 1, 0, 6'b101010, 2'd0);
    idle(LEN);
    tag_ov = "";

    // R9: illegal type code 2
    step(1, 1, 1, 6'h21, 2'd2);
    idle(LEN);

    // R5: reset mid-packet and starts during release window
    step(1, 1, 1, 6'h1F, 2'd0);
    step(1, 0, 0, '0, '0);
    do_reset();
    idle(2);

    for (int i = 0; i < 3000; i++) begin
      bit r;
      r = ($urandom_range(0, 199) != 0);
      step(r, ($urandom_range(0, 99) < 35), $urandom_range(0, 1),
           LEN'($urandom), TW'($urandom));
    end
    idle(LEN);
    finish_run();
  end
endmodule